// File: doc/BRIEF.md
# BCD Real-Time Clock Core with Transfer Buffers

This block keeps wall-clock time and a calendar. It holds seconds, minutes, hours, day of month, month, weekday and a two-digit year, all in packed BCD. A prescaler counts enable pulses from a 32.768 kHz reference and advances the seconds once per full count. Carries then ripple through minutes, hours, date, month and year. The date limit follows the month and a leap-year rule.

The hours byte carries its own format. When bit 7 is set, the hour runs 12, 1 through 11 and bit 5 flags the afternoon. When bit 7 is clear, the hour runs 00 to 23 and bit 5 is the tens digit for 20 to 23.

Software reaches the counters only through two buffer banks, gated by a transfer window `xferEn`. When the window opens, the read bank copies the live counters, so a multi-byte read sees one coherent instant. Bytes written while the window is open collect in the write bank. When the window closes, they are copied into the live counters in one step. Committing a new seconds value also clears the prescaler, so the first second after setting the time is a full second.

Top module: `bcd_rtc_top`

## Requirements
- R1: After reset, the read bank holds seconds 0x00, minutes 0x00, hours 0x00 (24-hour midnight), date 0x01, month 0x01, weekday 0x01 and year 0x00, at addresses 0 through 6 in that order. Address 7 reads 0x00.
- R2: The seconds value advances by one exactly once every `PRESCALE` clock cycles in which `refTick` is high. Cycles with `refTick` low do not advance it.
- R3: The read bank is loaded from the live counters in the cycle where `xferEn` goes from low to high. While `xferEn` stays high, `rdData` for a given `rdAddr` does not change, even if the counters advance.
- R4: A byte written with `wrEn` while `xferEn` is high reaches the live counters only in the cycle where `xferEn` falls. Only written addresses change. A write while `xferEn` is low, or to address 7, has no effect.
- R5: Committing a seconds byte clears the prescaler. The next second then advances after exactly `PRESCALE` further `refTick` cycles.
- R6: Seconds and minutes count 00 to 59 in BCD. Each wraps to 00 and carries into the next field.
- R7: In 24-hour mode (hours bit 7 = 0), the hour steps from 0x23 to 0x00. That step carries into the date and the weekday.
- R8: In 12-hour mode (hours bit 7 = 1, bit 5 = PM, bits 4:0 the BCD hour), 11 steps to 12 with the PM bit toggled, and 12 steps to 01. Only the step from 11 PM to 12 AM carries into the date.
- R9: The date wraps to 01 after 30 in April, June, September and November, and after 31 in the other months. February ends at 28, or at 29 when the BCD year is divisible by 4.
- R10: Month 0x12 wraps to 0x01 and carries into the year. Year 0x99 wraps to 0x00.
- R11: The weekday increments on each date carry and wraps from 0x07 to 0x01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| xferEn | input | 1 | Transfer window: rising edge loads the read bank, falling edge commits writes |
| refTick | input | 1 | One-cycle enable per 32.768 kHz reference period |
| wrEn | input | 1 | Write strobe into the write bank |
| wrAddr | input | 3 | Write address (0 sec, 1 min, 2 hour, 3 date, 4 month, 5 weekday, 6 year) |
| wrData | input | 8 | Write byte in BCD |
| rdAddr | input | 3 | Read address, same map as `wrAddr` |
| rdData | output | 8 | Read-bank byte, combinational from `rdAddr` |

## Verification
Three timings matter, and each is sampled at a falling clock edge after it takes effect.

- **Snapshot:** it is taken at the first rising edge with the window high, so reads are done from the next falling edge on.
- **Commit:** it lands at the first rising edge with the window low. The bench lets one full cycle pass before any further stimulus.
- **Seconds tick:** it lands on the rising edge that completes the `PRESCALE`-th `refTick` cycle. The bench holds `refTick` low except during counted pulse trains, so the number of elapsed seconds is exact.

Carry cases are set up as 23:59:59 plus the date under test, followed by one second of pulses.

// File: rtl/bcd_rtc_pkg.sv
package bcd_rtc_pkg;
  localparam int AW    = 3;
  localparam int NSLOT = 2 ** AW;
  localparam int NREG  = 7;

  typedef struct packed {
    logic             snap;    // load read bank
    logic             commit;  // copy dirty write bytes to live
    logic             tick;    // one second elapsed
    logic             bufWr;   // accepted write into write bank
    logic [NSLOT-1:0] dirty;   // bytes written in current window
  } rtcStb_t;
endpackage

// File: rtl/bcd_rtc_ctrl.sv
module bcd_rtc_ctrl
  import bcd_rtc_pkg::*;
#(
  parameter int PRESCALE = 32768
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          xferEn,
  input  logic          refTick,
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  output rtcStb_t       stb
);
  localparam int            CW       = $clog2(PRESCALE);
  localparam logic [CW-1:0] CNT_LAST = CW'(PRESCALE - 1);
  localparam logic [AW-1:0] ADDR_TOP = AW'(NREG - 1);

  logic             xferQ;
  logic [CW-1:0]    divCnt;
  logic [NSLOT-1:0] dirtyQ;
  logic             secCommit;

  always_comb begin
    stb.snap   = xferEn && !xferQ;
    stb.commit = !xferEn && xferQ;
    stb.bufWr  = xferEn && wrEn && (wrAddr <= ADDR_TOP);
    stb.dirty  = dirtyQ;
    secCommit  = stb.commit && dirtyQ[0];
    stb.tick   = refTick && (divCnt == CNT_LAST) && !secCommit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      xferQ  <= 1'b0;
      divCnt <= '0;
      dirtyQ <= '0;
    end else begin
      xferQ <= xferEn;
      if (stb.commit)     dirtyQ <= '0;
      else if (stb.bufWr) dirtyQ[wrAddr] <= 1'b1;
      if (secCommit)      divCnt <= '0;
      else if (refTick)   divCnt <= (divCnt == CNT_LAST) ? '0 : divCnt + 1'b1;
    end
  end
endmodule

// File: rtl/bcd_rtc_dp.sv
module bcd_rtc_dp
  import bcd_rtc_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  rtcStb_t       stb,
  input  logic [AW-1:0] wrAddr,
  input  logic [7:0]    wrData,
  input  logic [AW-1:0] rdAddr,
  output logic [7:0]    rdData,
  output logic [7:0]    secNow
);
  logic [7:0] live  [NSLOT];
  logic [7:0] adv   [NSLOT];
  logic [7:0] rdBuf [NSLOT];
  logic [7:0] wrBuf [NSLOT];

  function automatic logic [7:0] bcdInc(input logic [7:0] v);
    if (v[3:0] == 4'h9) return {v[7:4] + 4'h1, 4'h0};
    return v + 8'h01;
  endfunction

  function automatic logic leapYear(input logic [7:0] y);
    if (!y[4]) return (y[3:0] == 4'h0) || (y[3:0] == 4'h4) || (y[3:0] == 4'h8);
    return (y[3:0] == 4'h2) || (y[3:0] == 4'h6);
  endfunction

  function automatic logic [7:0] lastDay(input logic [7:0] m, input logic leap);
    case (m)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  always_comb begin
    logic       cSec, cMin, cDay, cDate, cMon;
    logic [7:0] hInc;
    cSec = 1'b0; cMin = 1'b0; cDay = 1'b0; cDate = 1'b0; cMon = 1'b0;
    hInc = bcdInc({3'b000, live[2][4:0]});
    for (int i = 0; i < NSLOT; i++) adv[i] = live[i];
    if (stb.tick) begin
      cSec   = (live[0] == 8'h59);
      adv[0] = cSec ? 8'h00 : bcdInc(live[0]);
    end
    if (cSec) begin
      cMin   = (live[1] == 8'h59);
      adv[1] = cMin ? 8'h00 : bcdInc(live[1]);
    end
    if (cMin) begin
      if (live[2][7]) begin
        if (live[2][4:0] == 5'h11) begin
          adv[2] = {2'b10, ~live[2][5], 5'h12};
          cDay   = live[2][5];
        end else if (live[2][4:0] == 5'h12) begin
          adv[2] = {live[2][7:5], 5'h01};
        end else begin
          adv[2] = {live[2][7:5], hInc[4:0]};
        end
      end else begin
        cDay   = (live[2] == 8'h23);
        adv[2] = cDay ? 8'h00 : bcdInc(live[2]);
      end
    end
    if (cDay) begin
      adv[5] = (live[5] == 8'h07) ? 8'h01 : live[5] + 8'h01;
      cDate  = (live[3] == lastDay(live[4], leapYear(live[6])));
      adv[3] = cDate ? 8'h01 : bcdInc(live[3]);
    end
    if (cDate) begin
      cMon   = (live[4] == 8'h12);
      adv[4] = cMon ? 8'h01 : bcdInc(live[4]);
    end
    if (cMon) adv[6] = (live[6] == 8'h99) ? 8'h00 : bcdInc(live[6]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NSLOT; i++) begin
        live[i]  <= ((i >= 3) && (i <= 5)) ? 8'h01 : 8'h00;
        rdBuf[i] <= 8'h00;
        wrBuf[i] <= 8'h00;
      end
    end else begin
      for (int i = 0; i < NSLOT; i++) begin
        live[i] <= (stb.commit && stb.dirty[i]) ? wrBuf[i] : adv[i];
        if (stb.snap) rdBuf[i] <= live[i];
      end
      if (stb.bufWr) wrBuf[wrAddr] <= wrData;
    end
  end

  assign rdData = rdBuf[rdAddr];
  assign secNow = live[0];
endmodule

// File: rtl/bcd_rtc_top.sv
module bcd_rtc_top
  import bcd_rtc_pkg::*;
#(
  parameter int PRESCALE = 32768
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       xferEn,
  input  logic       refTick,
  input  logic       wrEn,
  input  logic [2:0] wrAddr,
  input  logic [7:0] wrData,
  input  logic [2:0] rdAddr,
  output logic [7:0] rdData
);
  rtcStb_t    stb;
  logic [7:0] secNow;

  bcd_rtc_ctrl #(.PRESCALE(PRESCALE)) i_ctrl (
    .clk(clk), .rstN(rstN), .xferEn(xferEn), .refTick(refTick),
    .wrEn(wrEn), .wrAddr(wrAddr), .stb(stb)
  );

  bcd_rtc_dp i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .secNow(secNow)
  );
endmodule

// File: rtl/bcd_rtc_chk.sv
module bcd_rtc_chk #(
  parameter int PRESCALE = 32768
) (
  input logic       clk,
  input logic       rstN,
  input logic       xferEn,
  input logic       refTick,
  input logic [2:0] rdAddr,
  input logic [7:0] rdData,
  input logic       commit,
  input logic       tick,
  input logic       secCommit,
  input logic [7:0] secNow
);
  int unsigned refSeen;

  always_ff @(posedge clk) begin
    if (!rstN)                 refSeen <= 0;
    else if (secCommit || tick) refSeen <= 0;
    else if (refTick)           refSeen <= refSeen + 1;
  end

  // R2: a second elapses only after the full pulse count
  a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rstN)
    tick |-> refSeen == PRESCALE - 1);

  // R5: no second is skipped after a prescaler clear
  a_r5_no_overrun: assert property (@(posedge clk) disable iff (!rstN)
    refSeen < PRESCALE);

  // R3: read bank frozen while the window stays open
  a_r3_read_hold: assert property (@(posedge clk) disable iff (!rstN)
    xferEn && $past(xferEn) && $stable(rdAddr) |-> $stable(rdData));

  // R4: commits happen only on a window close
  a_r4_commit_on_close: assert property (@(posedge clk) disable iff (!rstN)
    commit |-> !xferEn && $past(xferEn));

  // R6: seconds remain legal BCD after each tick
  a_r6_sec_bcd: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> (secNow < 8'h60) && (secNow[3:0] < 4'hA));
endmodule

bind bcd_rtc_top bcd_rtc_chk #(.PRESCALE(PRESCALE)) u_chk (
  .clk(clk), .rstN(rstN), .xferEn(xferEn), .refTick(refTick),
  .rdAddr(rdAddr), .rdData(rdData), .commit(stb.commit), .tick(stb.tick),
  .secCommit(stb.commit && stb.dirty[0]), .secNow(secNow)
);

// File: tb/test_bcd_rtc_top.sv
module test_bcd_rtc_top;
  localparam int P = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       xferEn = 1'b0;
  logic       refTick = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [2:0] rdAddr = '0;
  logic [7:0] rdData;
  logic [7:0] rb [7];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bcd_rtc_top #(.PRESCALE(P)) i_bcd_rtc_top (
    .clk(clk), .rstN(rstN), .xferEn(xferEn), .refTick(refTick), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic pulse(input int n);
    @(negedge clk) refTick = 1'b1;
    repeat (n) @(negedge clk);
    refTick = 1'b0;
  endtask

  task automatic openWin();
    @(negedge clk) xferEn = 1'b1;
    @(negedge clk);
  endtask

  task automatic closeWin();
    xferEn = 1'b0;
    wrEn = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic peek(input int a, output logic [7:0] v);
    rdAddr = 3'(a);
    #1 v = rdData;
  endtask

  task automatic readAll();
    openWin();
    for (int i = 0; i < 7; i++) peek(i, rb[i]);
    closeWin();
  endtask

  task automatic writeAll(input logic [7:0] s, mi, h, d, mo, w, y);
    logic [7:0] v [7];
    v = '{s, mi, h, d, mo, w, y};
    @(negedge clk) xferEn = 1'b1;
    for (int i = 0; i < 7; i++) begin
      wrEn = 1'b1; wrAddr = 3'(i); wrData = v[i];
      @(negedge clk);
    end
    closeWin();
  endtask

  task automatic testReset();
    logic [7:0] v;
    readAll();
    chk("R1 sec", rb[0], 8'h00); chk("R1 min", rb[1], 8'h00);
    chk("R1 hour", rb[2], 8'h00); chk("R1 date", rb[3], 8'h01);
    chk("R1 month", rb[4], 8'h01); chk("R1 wday", rb[5], 8'h01);
    chk("R1 year", rb[6], 8'h00);
    openWin(); peek(7, v); closeWin();
    chk("R1 addr7", v, 8'h00);
  endtask

  task automatic testTick();
    pulse(3 * P); readAll(); chk("R2 three seconds", rb[0], 8'h03);
    pulse(P - 1); readAll(); chk("R2 short count", rb[0], 8'h03);
    repeat (5) @(negedge clk);
    readAll(); chk("R2 idle refTick", rb[0], 8'h03);
    pulse(1); readAll(); chk("R2 count complete", rb[0], 8'h04);
  endtask

  task automatic testPrescaleClear();
    pulse(5);
    @(negedge clk) xferEn = 1'b1; wrEn = 1'b1; wrAddr = 3'd0; wrData = 8'h10;
    @(negedge clk);
    closeWin();
    pulse(P - 1); readAll(); chk("R5 no early tick", rb[0], 8'h10);
    pulse(1); readAll(); chk("R5 full second", rb[0], 8'h11);
  endtask

  task automatic testWriteGate();
    logic [7:0] v;
    @(negedge clk) wrEn = 1'b1; wrAddr = 3'd1; wrData = 8'h33;
    @(negedge clk) wrEn = 1'b0;
    xferEn = 1'b1; @(negedge clk); closeWin();
    readAll(); chk("R4 write outside window", rb[1], 8'h00);
    @(negedge clk) xferEn = 1'b1; wrEn = 1'b1; wrAddr = 3'd1; wrData = 8'h45;
    @(negedge clk) wrAddr = 3'd7; wrData = 8'h77;
    @(negedge clk) wrEn = 1'b0;
    peek(1, v); chk("R4 not visible before close", v, 8'h00);
    closeWin();
    readAll();
    chk("R4 written minute", rb[1], 8'h45);
    chk("R4 unwritten second", rb[0], 8'h11);
    openWin(); peek(7, v); closeWin();
    chk("R4 addr7 ignored", v, 8'h00);
  endtask

  task automatic testSnapshot();
    logic [7:0] a, b;
    openWin(); peek(0, a);
    pulse(P);
    peek(0, b); closeWin();
    chk("R3 frozen during window", b, a);
    readAll(); chk("R3 fresh snapshot", rb[0], a + 8'h01);
  endtask

  task automatic stepCase(input string tag, input logic [7:0] h, d, mo, w, y,
                          input logic [7:0] eh, ed, emo, ew, ey);
    writeAll(8'h59, 8'h59, h, d, mo, w, y);
    pulse(P); readAll();
    chk({tag, " sec"}, rb[0], 8'h00); chk({tag, " min"}, rb[1], 8'h00);
    chk({tag, " hour"}, rb[2], eh); chk({tag, " date"}, rb[3], ed);
    chk({tag, " month"}, rb[4], emo); chk({tag, " wday"}, rb[5], ew);
    chk({tag, " year"}, rb[6], ey);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testTick();
    testPrescaleClear();
    testWriteGate();
    testSnapshot();
    stepCase("R6 minute carry", 8'h05, 8'h10, 8'h03, 8'h02, 8'h21, 8'h06, 8'h10, 8'h03, 8'h02, 8'h21);
    stepCase("R7 midnight",     8'h23, 8'h15, 8'h03, 8'h03, 8'h21, 8'h00, 8'h16, 8'h03, 8'h04, 8'h21);
    stepCase("R11 wday wrap",   8'h23, 8'h15, 8'h03, 8'h07, 8'h21, 8'h00, 8'h16, 8'h03, 8'h01, 8'h21);
    stepCase("R8 11am to 12pm", 8'h91, 8'h10, 8'h05, 8'h02, 8'h21, 8'hB2, 8'h10, 8'h05, 8'h02, 8'h21);
    stepCase("R8 12pm to 1pm",  8'hB2, 8'h10, 8'h05, 8'h02, 8'h21, 8'hA1, 8'h10, 8'h05, 8'h02, 8'h21);
    stepCase("R8 11pm to 12am", 8'hB1, 8'h10, 8'h05, 8'h02, 8'h21, 8'h92, 8'h11, 8'h05, 8'h03, 8'h21);
    stepCase("R9 april end",    8'h23, 8'h30, 8'h04, 8'h02, 8'h21, 8'h00, 8'h01, 8'h05, 8'h03, 8'h21);
    stepCase("R9 jan 30",       8'h23, 8'h30, 8'h01, 8'h02, 8'h21, 8'h00, 8'h31, 8'h01, 8'h03, 8'h21);
    stepCase("R9 feb common",   8'h23, 8'h28, 8'h02, 8'h02, 8'h23, 8'h00, 8'h01, 8'h03, 8'h03, 8'h23);
    stepCase("R9 feb leap 28",  8'h23, 8'h28, 8'h02, 8'h02, 8'h24, 8'h00, 8'h29, 8'h02, 8'h03, 8'h24);
    stepCase("R9 feb leap 29",  8'h23, 8'h29, 8'h02, 8'h02, 8'h24, 8'h00, 8'h01, 8'h03, 8'h03, 8'h24);
    stepCase("R10 year wrap",   8'h23, 8'h31, 8'h12, 8'h06, 8'h99, 8'h00, 8'h01, 8'h01, 8'h07, 8'h00);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule